// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall-clock time as a free-running 32-bit count of seconds. A one-cycle pulse on the tick input, produced elsewhere from a stable time base, advances the count by one. Software sets the time by writing a load register. It arms an alarm by writing a match register. When the count reaches the match value, a sticky raw status flag sets and, if the single-bit mask allows it, drives the interrupt output.

The host reaches the block through a simple word-addressed register port with select, write enable, address, write data and combinational read data. A write takes effect at the clock edge where select and write enable are both high. Read data follows the address in the same cycle. The control register always reports the clock as running. A small window at the top of the address space returns fixed identification bytes. Any write to the clear offset drops the alarm flag.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the count, match, load, mask and raw status all read 0, and `alarm_irq` is low.
- R2: A write to offset 0x08 makes the count equal the written data on the next cycle. Offset 0x08 reads back the last value written there. A load in the same cycle as a tick takes precedence over the tick.
- R3: Each cycle with `sec_tick` high and no load write increments the count by one, wrapping from 0xFFFFFFFF to 0. Offset 0x00 reads the count.
- R4: When a tick moves the count onto the match value (offset 0x04), raw status (offset 0x14, bit 0) is 1 from the next cycle. This includes a match value below the count, which is reached after the count wraps.
- R5: A write to the match or load register that leaves match equal to count sets raw status at once, visible the cycle after the write.
- R6: Offset 0x10 stores only bit 0 of written data as the mask. Offset 0x18 reads raw AND mask in bit 0, and `alarm_irq` equals that value.
- R7: Any write to offset 0x1C clears raw status, whatever the data. Raw status otherwise stays set. It does not set again while the count merely stays equal to match. A tick that reaches the match in the same cycle as a clear write wins, and the flag stays set.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Offsets 0xFE0, 0xFE4 … 0xFFC read, in that order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of offset 0x1C and of undefined offsets return 0. Writes to offsets 0x00, 0x14, 0x18 and to undefined offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable, qualified by select |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| alarm_irq | output | 1 | Masked alarm interrupt |

## Verification
Several checks run on every cycle. A load write lands exactly in the count, and a tick steps the count by one. The count holds when neither happens. A new raw flag only appears with count equal to match, and the flag stays sticky until cleared. A clear with no tick leaves it low. Masked-status reads agree with the interrupt pin, and the control offset reads 1. Only the bench's scenarios can show the rest: wrap-around alarms, the immediate fire when a load or match write creates equality, the load-versus-tick and clear-versus-match collisions, mask bit truncation, the identification byte order, and writes to read-only or unmapped offsets being ignored.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Word offsets of the register map (byte addresses)
    localparam int OFF_COUNT  = 'h000;
    localparam int OFF_MATCH  = 'h004;
    localparam int OFF_LOAD   = 'h008;
    localparam int OFF_CTRL   = 'h00C;
    localparam int OFF_MASK   = 'h010;
    localparam int OFF_RAW    = 'h014;
    localparam int OFF_MSTAT  = 'h018;
    localparam int OFF_CLEAR  = 'h01C;

    // Number of identification words at the top of the space
    localparam int ID_WORDS   = 8;

    typedef struct packed {
        logic load;
        logic match;
        logic mask;
        logic clear;
    } rtc_wstb_t;

    // Identification byte for word index 0..7 of the top window (R9)
    function automatic logic [7:0] rtc_id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output rtc_wstb_t         wstb
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              wr_en;

    assign word  = bus_addr[ADDR_W-1:2];
    assign wr_en = bus_sel & bus_wr;

    // Only writable registers get a strobe; count, status, control and
    // unmapped offsets decode to nothing (R8, R10)
    always_comb begin
        wstb       = '0;
        wstb.load  = wr_en && (word == WORD_W'(OFF_LOAD  >> 2));
        wstb.match = wr_en && (word == WORD_W'(OFF_MATCH >> 2));
        wstb.mask  = wr_en && (word == WORD_W'(OFF_MASK  >> 2));
        wstb.clear = wr_en && (word == WORD_W'(OFF_CLEAR >> 2));
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  rtc_wstb_t    wstb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] match,
    output logic [W-1:0] load,
    output logic         mask,
    output logic         raw
);
    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] match;
        logic [W-1:0] load;
        logic         mask;
        logic         raw;
    } core_state_t;

    core_state_t state_d, state_q;
    logic        event_d;

    always_comb begin
        state_d = state_q;
        event_d = 1'b0;

        // Load beats tick (R2); tick steps and wraps (R3)
        if (wstb.load) begin
            state_d.count = wdata;
            state_d.load  = wdata;
            event_d       = 1'b1;
        end else if (tick) begin
            state_d.count = state_q.count + W'(1);
            event_d       = 1'b1;
        end

        if (wstb.match) begin
            state_d.match = wdata;
            event_d       = 1'b1;
        end

        // Only bit 0 of the mask write is kept (R6)
        if (wstb.mask) begin
            state_d.mask = wdata[0];
        end

        // Clear on any data (R7)
        if (wstb.clear) begin
            state_d.raw = 1'b0;
        end

        // Alarm fires on a fresh equality against the updated values (R4, R5)
        if (event_d && (state_d.count == state_d.match)) begin
            state_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.count;
    assign match = state_q.match;
    assign load  = state_q.load;
    assign mask  = state_q.mask;
    assign raw   = state_q.raw;

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      match,
    input  logic [W-1:0]      load,
    input  logic              mask,
    input  logic              raw,
    output logic [W-1:0]      rdata
);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int ID_BASE = (1 << WORD_W) - ID_WORDS;

    logic [WORD_W-1:0] word;
    logic              in_id;

    assign word  = bus_addr[ADDR_W-1:2];
    assign in_id = (word >= WORD_W'(ID_BASE));

    always_comb begin
        rdata = '0;
        if (in_id) begin
            rdata = W'(rtc_id_byte(word[2:0]));          // R9
        end else begin
            case (word)
                WORD_W'(OFF_COUNT >> 2): rdata = count;  // R3
                WORD_W'(OFF_MATCH >> 2): rdata = match;
                WORD_W'(OFF_LOAD  >> 2): rdata = load;   // R2
                WORD_W'(OFF_CTRL  >> 2): rdata = W'(1);  // R8
                WORD_W'(OFF_MASK  >> 2): rdata = W'(mask);
                WORD_W'(OFF_RAW   >> 2): rdata = W'(raw);
                WORD_W'(OFF_MSTAT >> 2): rdata = W'(raw & mask); // R6
                default:                 rdata = '0;     // R10
            endcase
        end
    end

endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              alarm_irq
);
    rtc_wstb_t    wstb;
    logic [W-1:0] cur_count;
    logic [W-1:0] cur_match;
    logic [W-1:0] cur_load;
    logic         cur_mask;
    logic         cur_raw;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wstb     (wstb)
    );

    rtc_time_core #(.W(W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .wstb  (wstb),
        .wdata (bus_wdata),
        .count (cur_count),
        .match (cur_match),
        .load  (cur_load),
        .mask  (cur_mask),
        .raw   (cur_raw)
    );

    rtc_read_mux #(.W(W), .ADDR_W(ADDR_W)) u_rmux (
        .bus_addr (bus_addr),
        .count    (cur_count),
        .match    (cur_match),
        .load     (cur_load),
        .mask     (cur_mask),
        .raw      (cur_raw),
        .rdata    (bus_rdata)
    );

    // Interrupt pin mirrors the masked status (R6)
    assign alarm_irq = cur_raw & cur_mask;

endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
module rtc_seconds_alarm_chk
    import rtc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic              alarm_irq,
    input logic [W-1:0]      cur_count,
    input logic [W-1:0]      cur_match,
    input logic              cur_mask,
    input logic              cur_raw
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic is_ld, is_clr, rd_ctrl, rd_mstat;

    assign word     = bus_addr[ADDR_W-1:2];
    assign is_ld    = bus_sel && bus_wr  && (word == WORD_W'(OFF_LOAD  >> 2));
    assign is_clr   = bus_sel && bus_wr  && (word == WORD_W'(OFF_CLEAR >> 2));
    assign rd_ctrl  = bus_sel && !bus_wr && (word == WORD_W'(OFF_CTRL  >> 2));
    assign rd_mstat = bus_sel && !bus_wr && (word == WORD_W'(OFF_MSTAT >> 2));

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        is_ld |=> (cur_count == $past(bus_wdata)));                          // R2
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !is_ld) |=> (cur_count == $past(cur_count) + W'(1)));   // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !is_ld) |=> $stable(cur_count));                       // R10
    AST_RAW_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_raw) |-> (cur_count == cur_match));                        // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_clr && !sec_tick) |=> !cur_raw);                                 // R7
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_raw && !is_clr) |=> cur_raw);                                   // R7
    AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mstat |-> (bus_rdata[0] == alarm_irq));                           // R6
    AST_CTRL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> (bus_rdata == W'(1)));                                   // R8

endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alarm_irq (alarm_irq),
    .cur_count (cur_count),
    .cur_match (cur_match),
    .cur_mask  (cur_mask),
    .cur_raw   (cur_raw)
);

// File: tb/rtc_seconds_alarm_test.sv
module rtc_seconds_alarm_test;

    localparam int W      = 32;
    localparam int ADDR_W = 12;

    // kind: 0 = write, 1 = read and compare, 2 = tick data times
    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [W-1:0]      data;
        logic [W-1:0]      expv;
        logic [7:0]        req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 12'h00C, 32'd0,          32'd1,    8'd8},  // R8 control reads 1
        '{2'd0, 12'h008, 32'd100,        32'd0,    8'd2},  // R2 load 100
        '{2'd1, 12'h000, 32'd0,          32'd100,  8'd2},  // R2 count
        '{2'd1, 12'h008, 32'd0,          32'd100,  8'd2},  // R2 load readback
        '{2'd2, 12'h000, 32'd5,          32'd0,    8'd3},  // R3 five ticks
        '{2'd1, 12'h000, 32'd0,          32'd105,  8'd3},  // R3
        '{2'd0, 12'h004, 32'd108,        32'd0,    8'd4},  // R4 arm match
        '{2'd1, 12'h004, 32'd0,          32'd108,  8'd4},
        '{2'd1, 12'h014, 32'd0,          32'd0,    8'd4},  // R4 not yet
        '{2'd2, 12'h000, 32'd3,          32'd0,    8'd4},
        '{2'd1, 12'h014, 32'd0,          32'd1,    8'd4},  // R4 fired
        '{2'd1, 12'h018, 32'd0,          32'd0,    8'd6},  // R6 masked off
        '{2'd0, 12'h010, 32'hFFFFFFFE,   32'd0,    8'd6},  // R6 bit0 only
        '{2'd1, 12'h010, 32'd0,          32'd0,    8'd6},
        '{2'd0, 12'h010, 32'd3,          32'd0,    8'd6},
        '{2'd1, 12'h010, 32'd0,          32'd1,    8'd6},
        '{2'd1, 12'h018, 32'd0,          32'd1,    8'd6},
        '{2'd0, 12'h01C, 32'd0,          32'd0,    8'd7},  // R7 clear, data 0
        '{2'd1, 12'h014, 32'd0,          32'd0,    8'd7},
        '{2'd0, 12'h000, 32'h55,         32'd0,    8'd10}, // R10 write count ignored
        '{2'd0, 12'h014, 32'd1,          32'd0,    8'd10}, // R10 write raw ignored
        '{2'd1, 12'h000, 32'd0,          32'd108,  8'd10},
        '{2'd1, 12'h014, 32'd0,          32'd0,    8'd10},
        '{2'd0, 12'h00C, 32'd0,          32'd0,    8'd8},  // R8 write control
        '{2'd1, 12'h00C, 32'd0,          32'd1,    8'd8},
        '{2'd1, 12'h01C, 32'd0,          32'd0,    8'd10}, // R10 clear reads 0
        '{2'd1, 12'h200, 32'd0,          32'd0,    8'd10}, // R10 undefined
        '{2'd1, 12'hFE0, 32'd0,          32'h31,   8'd9},  // R9
        '{2'd1, 12'hFF0, 32'd0,          32'h0D,   8'd9},  // R9
        '{2'd1, 12'hFFC, 32'd0,          32'hB1,   8'd9}   // R9
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_tick = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic              alarm_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rtc_seconds_alarm #(.W(W), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    task automatic check(input int req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d, input logic tk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = tk;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic rd_chk(input int req, input string what,
                          input logic [ADDR_W-1:0] a, input logic [W-1:0] expv);
        logic [W-1:0] v;
        rd(a, v);
        check(req, what, v, expv);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(1, "reset count", 12'h000, 32'd0);
        rd_chk(1, "reset match", 12'h004, 32'd0);
        rd_chk(1, "reset load",  12'h008, 32'd0);
        rd_chk(1, "reset mask",  12'h010, 32'd0);
        rd_chk(1, "reset raw",   12'h014, 32'd0);
        check(1, "reset irq", W'(alarm_irq), 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].kind)
                2'd0: wr(VEC[i].addr, VEC[i].data, 1'b0);
                2'd1: rd_chk(int'(VEC[i].req), $sformatf("vector %0d", i),
                             VEC[i].addr, VEC[i].expv);
                default: ticks(int'(VEC[i].data));
            endcase
        end
        // R6 irq pin with mask 1 and raw 0 after clear
        check(6, "irq low after clear", W'(alarm_irq), 32'd0);

        // R5 load onto the match value fires at once
        wr(12'h008, 32'd108, 1'b0);
        rd_chk(5, "load equals match", 12'h014, 32'd1);
        check(6, "irq high", W'(alarm_irq), 32'd1);
        wr(12'h01C, 32'hDEAD, 1'b0);
        // R7 count still equal, no new event: stays clear
        ticks(0);
        @(negedge clk);
        rd_chk(7, "no refire while equal", 12'h014, 32'd0);
        // R5 match write equal to count fires at once
        wr(12'h004, 32'd108, 1'b0);
        rd_chk(5, "match equals count", 12'h014, 32'd1);
        wr(12'h01C, 32'd0, 1'b0);

        // R3 and R4 wrap: match below count fires after wrap
        wr(12'h008, 32'hFFFFFFFE, 1'b0);
        wr(12'h004, 32'd1, 1'b0);
        ticks(2);
        rd_chk(3, "wrapped count", 12'h000, 32'd0);
        rd_chk(4, "not yet after wrap", 12'h014, 32'd0);
        ticks(1);
        rd_chk(4, "fire after wrap", 12'h014, 32'd1);
        wr(12'h01C, 32'd0, 1'b0);

        // R2 load and tick in the same cycle: load wins
        wr(12'h008, 32'd50, 1'b1);
        rd_chk(2, "load beats tick", 12'h000, 32'd50);

        // R7 clear and matching tick in the same cycle: set wins
        wr(12'h004, 32'd52, 1'b0);
        ticks(1);
        rd_chk(7, "raw low before", 12'h014, 32'd0);
        wr(12'h01C, 32'd0, 1'b1);
        rd_chk(7, "tick match beats clear", 12'h014, 32'd1);
        wr(12'h01C, 32'd0, 1'b0);
        rd_chk(7, "clear alone", 12'h014, 32'd0);

        // R10 write to undefined offset leaves state
        wr(12'h300, 32'hFFFFFFFF, 1'b0);
        rd_chk(10, "undef write match", 12'h004, 32'd52);
        rd_chk(10, "undef write load",  12'h008, 32'd50);

        finish_up();
    end

endmodule